// File: doc/BRIEF.md
# Conversion Clock Strobe and Warm-Up Timer

This block sits between a conversion sequencer and a successive-approximation converter. It runs on a 1 MHz base clock, so one base cycle is one microsecond. It produces a one-cycle clock-enable strobe, `conv_tick`, that paces the converter's bit steps. The strobe rate is picked by a 3-bit select code as a power-of-two fraction of the base clock. The block does not produce a derived clock.

Before the converter may start, its analog front end needs a warm-up interval. A 2-bit option picks this interval, from 400 µs up to 1000 µs. The sequencer holds `start_req` high for as long as it wants a conversion. The block raises `ready` once the converter is warmed and powered, and only then do strobes appear.

- **Successive mode off:** the converter is powered down whenever the request drops. Every new request pays the full warm-up again.
- **Successive mode on:** only the first request warms up. The converter then stays powered, so later requests are granted at once.
- **Oscillator enable low:** everything is held powered down.

Top module: `conv_clk_timer`

## Requirements
- R1: While `rst_n` is low, `ready` and `conv_tick` are 0, whatever the other inputs are.
- R2: From the powered-down state, when `osc_en` and `start_req` are both high, `ready` rises at the T-th rising clock edge after the edge that first samples the request. T is set by `warm_opt`: 00 gives 1000, 01 gives 800, 10 gives 600 and 11 gives 400 base cycles.
- R3: While `ready` is high, `conv_tick` is a one-cycle pulse with period 2^s cycles, where s is the value of `clk_sel` (000 = every cycle, 111 = every 128 cycles). The first pulse falls in the 2^s-th cycle in which `ready` is high.
- R4: `conv_tick` is never high while `ready` is low.
- R5: With `succ_mode` low, dropping `start_req` after `ready` powers the converter down. The next request waits the full T again.
- R6: With `succ_mode` high, once a first request has warmed up, a later request drives `ready` high in the same cycle the request is raised, with no warm-up wait.
- R7: While `osc_en` is low, requests are ignored and `ready` and `conv_tick` stay 0. Clearing `osc_en` while `ready` is high drops `ready` after the next clock edge.
- R8: Clearing `succ_mode` while powered and idle powers the converter down. The next request waits the full T.
- R9: Dropping `start_req` during warm-up aborts it. A new request restarts the full T count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1 MHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator enable; low forces power-down |
| succ_mode | input | 1 | Keep converter powered between conversions |
| clk_sel | input | 3 | Strobe divide code, period 2^clk_sel |
| warm_opt | input | 2 | Warm-up interval option |
| start_req | input | 1 | Conversion request level from sequencer |
| conv_tick | output | 1 | One-cycle converter clock-enable strobe |
| ready | output | 1 | Converter warmed and granted to the sequencer |

## Verification
The in-line assertions check several properties on every cycle:
- a strobe only occurs with `ready` high;
- two strobes are never adjacent at a nonzero divide code;
- a low `osc_en` always leads to power-down;
- a dropped request without successive mode always leads to power-down;
- an aborted warm-up returns to the powered-down state;
- the powered state is only ever entered from an expired warm-up.

The exact warm-up lengths per option, the strobe phase and period for each select code, and whether a repeated request is granted at once or waits again depend on sequences of requests. Only the bench's scenarios can show these.

// File: rtl/ccs_pkg.sv
`timescale 1ns/1ps
package ccs_pkg;

  typedef enum logic [1:0] {
    PWR_OFF  = 2'd0,
    PWR_WARM = 2'd1,
    PWR_ON   = 2'd2
  } pwr_state_e;

  // Warm-up length in base cycles: the largest option code gives the base,
  // each step down in code adds one step.
  function automatic int warm_cycles(input int opt, input int opt_w,
                                     input int base, input int step);
    return base + (((1 << opt_w) - 1) - opt) * step;
  endfunction

  // Low-bit mask selecting a divide-by-2^sel phase.
  function automatic int div_mask(input int sel);
    return (1 << sel) - 1;
  endfunction

endpackage

// File: rtl/ccs_warmup_timer.sv
`timescale 1ns/1ps
module ccs_warmup_timer #(
  parameter int OPT_W = 2,
  parameter int BASE  = 400,
  parameter int STEP  = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             count_en,
  input  logic [OPT_W-1:0] opt,
  output logic             expire
);
  import ccs_pkg::*;

  localparam int MAX_T = warm_cycles(0, OPT_W, BASE, STEP);
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] target;

  always_comb begin
    target = CNT_W'(warm_cycles(int'(opt), OPT_W, BASE, STEP) - 1);
    expire = count_en && (cnt_q == target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!count_en)
      cnt_q <= '0;
    else if (!expire)
      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/ccs_tick_divider.sv
`timescale 1ns/1ps
module ccs_tick_divider #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import ccs_pkg::*;

  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = DIV_W'(div_mask(int'(sel)));
    tick = run && ((phase_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (!run)
      phase_q <= '0;
    else
      phase_q <= phase_q + 1'b1;
  end

  // R3
  no_adjacent_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || !$stable(sel)));

endmodule

// File: rtl/ccs_power_fsm.sv
`timescale 1ns/1ps
module ccs_power_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic succ_mode,
  input  logic start_req,
  input  logic warm_expire,
  output logic warming,
  output logic ready
);
  import ccs_pkg::*;

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_OFF:  if (osc_en && start_req) state_d = PWR_WARM;
      PWR_WARM: begin
        if (!osc_en || !start_req) state_d = PWR_OFF;
        else if (warm_expire)      state_d = PWR_ON;
      end
      PWR_ON: begin
        if (!osc_en)                       state_d = PWR_OFF;
        else if (!start_req && !succ_mode) state_d = PWR_OFF;
      end
      default: state_d = PWR_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_OFF;
    else        state_q <= state_d;
  end

  assign warming = (state_q == PWR_WARM);
  assign ready   = (state_q == PWR_ON) && start_req;

  // R7
  osc_off_powers_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (state_q == PWR_OFF));

  // R5
  drop_without_succ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_ON && !start_req && !succ_mode) |=> (state_q == PWR_OFF));

  // R9
  warm_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_WARM && !start_req) |=> (state_q == PWR_OFF));

  // R2
  on_only_after_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PWR_ON && $past(state_q) != PWR_ON)
      |-> ($past(state_q) == PWR_WARM && $past(warm_expire)));

endmodule

// File: rtl/conv_clk_timer.sv
`timescale 1ns/1ps
module conv_clk_timer #(
  parameter int SEL_W     = 3,
  parameter int OPT_W     = 2,
  parameter int WARM_BASE = 400,
  parameter int WARM_STEP = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             succ_mode,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic [OPT_W-1:0] warm_opt,
  input  logic             start_req,
  output logic             conv_tick,
  output logic             ready
);

  logic warming;
  logic warm_expire;

  ccs_power_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .succ_mode   (succ_mode),
    .start_req   (start_req),
    .warm_expire (warm_expire),
    .warming     (warming),
    .ready       (ready)
  );

  ccs_warmup_timer #(
    .OPT_W (OPT_W),
    .BASE  (WARM_BASE),
    .STEP  (WARM_STEP)
  ) u_warm (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (warming),
    .opt      (warm_opt),
    .expire   (warm_expire)
  );

  ccs_tick_divider #(
    .SEL_W (SEL_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (ready),
    .sel   (clk_sel),
    .tick  (conv_tick)
  );

  // R4
  tick_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_tick |-> ready);

endmodule

// File: tb/conv_clk_timer_test.sv
`timescale 1ns/1ps
module conv_clk_timer_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       succ_mode = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic [1:0] warm_opt = 2'd0;
  logic       start_req = 1'b0;
  logic       conv_tick;
  logic       ready;

  int checks = 0;
  int errors = 0;

  // columns: warm option, select code, warm-up cycles, strobe period
  localparam int TBL [6][4] = '{
    '{0, 1, 1000,   2},
    '{1, 0,  800,   1},
    '{2, 3,  600,   8},
    '{3, 7,  400, 128},
    '{3, 2,  400,   4},
    '{2, 5,  600,  32}
  };

  always #4 clk = ~clk;

  conv_clk_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_en    (osc_en),
    .succ_mode (succ_mode),
    .clk_sel   (clk_sel),
    .warm_opt  (warm_opt),
    .start_req (start_req),
    .conv_tick (conv_tick),
    .ready     (ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts falling edges until ready is seen; T+1 means ready rose at the
  // T-th rising edge after the edge that sampled the request.
  task automatic wait_ready(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!ready && n < 3000);
  endtask

  task automatic tick_scan(input int p, output int first, output int cnt);
    first = -1;
    cnt = 0;
    for (int j = 0; j < 4 * p; j++) begin
      if (conv_tick) begin
        cnt++;
        if (first < 0) first = j;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, first, cnt, seen_r, seen_t;

    // R1: reset holds outputs low even with request and oscillator on
    osc_en = 1'b1;
    start_req = 1'b1;
    repeat (5) @(negedge clk);
    check(ready == 1'b0, "R1 ready", int'(ready), 0);
    check(conv_tick == 1'b0, "R1 tick", int'(conv_tick), 0);
    start_req = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 table walk
    for (int i = 0; i < 6; i++) begin
      warm_opt = 2'(TBL[i][0]);
      clk_sel = 3'(TBL[i][1]);
      succ_mode = 1'b0;
      start_req = 1'b1;
      wait_ready(n);
      check(n == TBL[i][2] + 1, "R2 warm-up length", n, TBL[i][2] + 1);
      tick_scan(TBL[i][3], first, cnt);
      check(first == TBL[i][3] - 1, "R3 first strobe", first, TBL[i][3] - 1);
      check(cnt == 4, "R3 strobe count", cnt, 4);
      start_req = 1'b0;
      repeat (2) @(negedge clk);
    end

    // R5: no successive mode, repeated request waits full time
    warm_opt = 2'd3;
    clk_sel = 3'd0;
    start_req = 1'b1;
    wait_ready(n);
    start_req = 1'b0;
    repeat (3) @(negedge clk);
    start_req = 1'b1;
    wait_ready(n);
    check(n == 401, "R5 repeat warm-up", n, 401);
    start_req = 1'b0;
    repeat (2) @(negedge clk);

    // R6: successive mode grants later request at once
    succ_mode = 1'b1;
    start_req = 1'b1;
    wait_ready(n);
    check(n == 401, "R6 first warm-up", n, 401);
    start_req = 1'b0;
    repeat (3) @(negedge clk);
    check(ready == 1'b0, "R6 idle ready", int'(ready), 0);
    start_req = 1'b1;
    #1;
    check(ready == 1'b1, "R6 immediate ready", int'(ready), 1);
    check(conv_tick == 1'b1, "R3 immediate strobe sel 0", int'(conv_tick), 1);
    @(negedge clk);

    // R8: clearing successive mode while idle powers down
    start_req = 1'b0;
    succ_mode = 1'b0;
    repeat (2) @(negedge clk);
    start_req = 1'b1;
    wait_ready(n);
    check(n == 401, "R8 warm-up after clearing", n, 401);
    start_req = 1'b0;
    repeat (2) @(negedge clk);

    // R7: oscillator off ignores requests
    osc_en = 1'b0;
    start_req = 1'b1;
    seen_r = 0;
    seen_t = 0;
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk);
      if (ready) seen_r++;
      if (conv_tick) seen_t++;
    end
    check(seen_r == 0, "R7 ready while osc off", seen_r, 0);
    check(seen_t == 0, "R4 strobe while not ready", seen_t, 0);
    osc_en = 1'b1;
    wait_ready(n);
    check(n == 401, "R7 warm-up after osc on", n, 401);
    osc_en = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R7 ready after osc clear", int'(ready), 0);
    start_req = 1'b0;
    osc_en = 1'b1;
    repeat (2) @(negedge clk);

    // R9: aborted warm-up restarts the full count
    start_req = 1'b1;
    repeat (150) @(negedge clk);
    start_req = 1'b0;
    @(negedge clk);
    start_req = 1'b1;
    wait_ready(n);
    check(n == 401, "R9 restart warm-up", n, 401);
    start_req = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule